// File: doc/BRIEF.md
# Command Queue Front End for a 2D Drawing Engine

This block sits between a host with a 16-bit register bus and a 2D drawing engine that consumes 32-bit command words. The host splits each command into two half-word writes. First it writes the upper half to a high-half register, then the lower half to a low-half register. The write to the low half joins the two halves and queues the result. Queued words go out to the engine in arrival order over a valid/ready handshake.

The host checks a pending-word count and a free-space count before it sends a burst of words. A one-bit clear write flushes the queue. A sticky overflow flag records any word that was dropped because the queue was full. An idle output tells the host that all work is done: the queue is empty and the engine reports that it is not busy.

Top module: `cmdq_front`

## Requirements
- R1: After reset the outputs are as follows: `pend_cnt` is 0, `free_cnt` is DEPTH, `cmd_valid` is 0 and `ovf` is 0.
- R2: A write to the high half only latches `hi_data` and queues nothing. A write to the low half queues the word {latched high half, `lo_data`}, with the high half in bits 31:16. The word is visible after that clock edge.
- R3: A low-half write reuses the most recently latched high half if no new high write came before it. When a high write and a low write arrive in the same cycle, the queued word uses the previously latched high half, and the new high half is latched for later words.
- R4: `cmd_valid` is 1 exactly when `pend_cnt` is nonzero. `cmd_data` shows the oldest queued word and holds steady until the engine takes it with `cmd_valid && cmd_ready`. Words leave in the order they were queued.
- R5: `pend_cnt` counts the queued words, including the word on offer to the engine, until that word is accepted. `free_cnt` equals DEPTH minus `pend_cnt`.
- R6: A low-half write is dropped when `pend_cnt` equals DEPTH at that clock edge, even if a pop happens in the same cycle. The dropped write leaves the queue contents unchanged and sets `ovf`. `ovf` stays set until a clear.
- R7: A clear write (`clr_we` with `clr_val` = 1) empties the queue and clears `ovf`. A low-half write in the same cycle is discarded. A clear write with `clr_val` = 0 has no effect.
- R8: `idle` is 1 exactly when `pend_cnt` is 0 and `eng_busy` is 0.
- R9: `cmd_ready` while the queue is empty has no effect.
- R10: A push and a pop in the same cycle on a queue that is not full leave `pend_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_we | input | 1 | Write strobe for the high-half register |
| hi_data | input | 16 | Upper 16 bits of the next command |
| lo_we | input | 1 | Write strobe for the low-half register; queues a word |
| lo_data | input | 16 | Lower 16 bits of the command |
| clr_we | input | 1 | Write strobe for the clear register |
| clr_val | input | 1 | Clear register data; 1 flushes the queue |
| eng_busy | input | 1 | Engine is still executing a command |
| cmd_valid | output | 1 | A queued word is on offer |
| cmd_data | output | 32 | Oldest queued word |
| cmd_ready | input | 1 | Engine accepts the offered word |
| pend_cnt | output | clog2(DEPTH+1) | Number of queued words |
| free_cnt | output | clog2(DEPTH+1) | Number of free entries |
| ovf | output | 1 | Sticky overflow flag |
| idle | output | 1 | Queue is empty and the engine is not busy |

## Verification
The bound checker tests these properties on every cycle:
- the count stays within DEPTH;
- a push or a high-only write moves the count as expected;
- the offered word holds steady while it is stalled;
- the overflow flag stays set until a clear;
- a clear empties the queue;
- `idle` agrees with the count and `eng_busy`.

Some behaviour only the bench scenarios can show. These cover:
- how the two halves are paired, including reuse of the latched high half and a same-cycle high and low write;
- arrival order across a full wrap of the storage;
- the dropped word at capacity leaving the contents untouched;
- that the data path returns exactly what was written.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t join_halves(input half_t upper, input half_t lower);
        return {upper, lower};
    endfunction
endpackage

// File: rtl/cmdq_assemble.sv
module cmdq_assemble
    import cmdq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hi_we,
    input  half_t hi_data,
    input  logic  lo_we,
    input  half_t lo_data,
    output logic  push,
    output word_t push_word
);
    typedef struct packed {
        half_t upper;
    } asm_state_t;

    asm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hi_we) begin
            st_d.upper = hi_data;
        end
        // the word always takes the half latched before this edge
        push      = lo_we;
        push_word = join_halves(st_q.upper, lo_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cmdq_fifo.sv
module cmdq_fifo
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  word_t                        push_word,
    input  logic                         pop_ready,
    output logic                         out_valid,
    output word_t                        out_word,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         drop
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    word_t       mem [DEPTH];
    logic        take_push;
    logic        take_pop;

    always_comb begin
        st_d      = st_q;
        take_push = push && !flush && (st_q.cnt != FULL_CNT);
        take_pop  = !flush && (st_q.cnt != '0) && pop_ready;
        drop      = push && !flush && (st_q.cnt == FULL_CNT);
        if (flush) begin
            st_d.cnt    = '0;
            st_d.rd_ptr = st_q.wr_ptr;
        end else begin
            if (take_push) begin
                st_d.wr_ptr = st_q.wr_ptr + 1'b1;
            end
            if (take_pop) begin
                st_d.rd_ptr = st_q.rd_ptr + 1'b1;
            end
            case ({take_push, take_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (take_push) begin
            mem[st_q.wr_ptr] <= push_word;
        end
    end

    assign out_valid = (st_q.cnt != '0);
    assign out_word  = mem[st_q.rd_ptr];
    assign count     = st_q.cnt;
endmodule

// File: rtl/cmdq_status.sv
module cmdq_status #(
    parameter int DEPTH = 512
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         drop,
    input  logic                         eng_busy,
    input  logic [$clog2(DEPTH+1)-1:0]   count,
    output logic [$clog2(DEPTH+1)-1:0]   free_cnt,
    output logic                         ovf,
    output logic                         idle
);
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic ovf;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.ovf = 1'b0;
        end else if (drop) begin
            st_d.ovf = 1'b1;
        end
        free_cnt = CNT_W'(DEPTH) - count;
        idle     = (count == '0) && !eng_busy;
        ovf      = st_q.ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cmdq_front.sv
module cmdq_front #(
    parameter int DEPTH = 512
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hi_we,
    input  logic [15:0]                  hi_data,
    input  logic                         lo_we,
    input  logic [15:0]                  lo_data,
    input  logic                         clr_we,
    input  logic                         clr_val,
    input  logic                         eng_busy,
    output logic                         cmd_valid,
    output logic [31:0]                  cmd_data,
    input  logic                         cmd_ready,
    output logic [$clog2(DEPTH+1)-1:0]   pend_cnt,
    output logic [$clog2(DEPTH+1)-1:0]   free_cnt,
    output logic                         ovf,
    output logic                         idle
);
    logic        flush;
    logic        push;
    logic [31:0] push_word;
    logic        drop;

    assign flush = clr_we && clr_val;

    cmdq_assemble u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_we     (hi_we),
        .hi_data   (hi_data),
        .lo_we     (lo_we),
        .lo_data   (lo_data),
        .push      (push),
        .push_word (push_word)
    );

    cmdq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_word (push_word),
        .pop_ready (cmd_ready),
        .out_valid (cmd_valid),
        .out_word  (cmd_data),
        .count     (pend_cnt),
        .drop      (drop)
    );

    cmdq_status #(.DEPTH(DEPTH)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .drop     (drop),
        .eng_busy (eng_busy),
        .count    (pend_cnt),
        .free_cnt (free_cnt),
        .ovf      (ovf),
        .idle     (idle)
    );
endmodule

// File: rtl/cmdq_front_chk.sv
module cmdq_front_chk #(
    parameter int DEPTH = 512
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         hi_we,
    input logic                         lo_we,
    input logic                         clr_we,
    input logic                         clr_val,
    input logic                         eng_busy,
    input logic                         cmd_valid,
    input logic [31:0]                  cmd_data,
    input logic                         cmd_ready,
    input logic [$clog2(DEPTH+1)-1:0]   pend_cnt,
    input logic                         ovf,
    input logic                         idle
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic clr_req;
    logic popping;
    assign clr_req = clr_we && clr_val;
    assign popping = cmd_valid && cmd_ready;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= FULL_CNT); // R5

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we && !clr_req && !popping && pend_cnt < FULL_CNT)
        |=> pend_cnt == $past(pend_cnt) + 1'b1); // R2

    AST_HIGH_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && !lo_we && !clr_req && !popping) |=> $stable(pend_cnt)); // R2

    AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !clr_req) |=> cmd_valid && $stable(cmd_data)); // R4

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt == FULL_CNT && lo_we && !clr_req && !popping)
        |=> pend_cnt == FULL_CNT && ovf); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_req) |=> ovf); // R6

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> pend_cnt == '0 && !ovf && !cmd_valid); // R7

    AST_IDLE_MEANING: assert property (@(posedge clk) disable iff (!rst_n)
        idle == (pend_cnt == '0 && !eng_busy)); // R8
endmodule

bind cmdq_front cmdq_front_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi_we     (hi_we),
    .lo_we     (lo_we),
    .clr_we    (clr_we),
    .clr_val   (clr_val),
    .eng_busy  (eng_busy),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .cmd_ready (cmd_ready),
    .pend_cnt  (pend_cnt),
    .ovf       (ovf),
    .idle      (idle)
);

// File: tb/test_cmdq_front.sv
module test_cmdq_front;
    localparam int DEPTH = 512;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hi_we = 1'b0, lo_we = 1'b0, clr_we = 1'b0, clr_val = 1'b0;
    logic [15:0]      hi_data = '0, lo_data = '0;
    logic             eng_busy = 1'b0, cmd_ready = 1'b0;
    logic             cmd_valid, ovf, idle;
    logic [31:0]      cmd_data;
    logic [CNT_W-1:0] pend_cnt, free_cnt;

    always #2.5 clk = ~clk;

    cmdq_front #(.DEPTH(DEPTH)) i_cmdq_front (
        .clk(clk), .rst_n(rst_n), .hi_we(hi_we), .hi_data(hi_data),
        .lo_we(lo_we), .lo_data(lo_data), .clr_we(clr_we), .clr_val(clr_val),
        .eng_busy(eng_busy), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .pend_cnt(pend_cnt), .free_cnt(free_cnt),
        .ovf(ovf), .idle(idle)
    );

    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [31:0] m_q[$];
    logic [15:0] m_hi = '0;
    bit          m_ovf = 1'b0;
    bit          m_busy = 1'b0;

    task automatic expect_eq(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [15:0] h, input logic [15:0] l);
        return {h, l};
    endfunction

    task automatic compare_all();
        expect_eq("R5 pend_cnt", pend_cnt, m_q.size());
        expect_eq("R5 free_cnt", free_cnt, DEPTH - m_q.size());
        expect_eq("R4 cmd_valid", cmd_valid, m_q.size() != 0);
        if (m_q.size() != 0) expect_eq("R4 cmd_data", cmd_data, m_q[0]);
        expect_eq("R6 ovf", ovf, m_ovf);
        expect_eq("R8 idle", idle, (m_q.size() == 0) && !m_busy);
    endtask

    // drive at negedge, update model, sample after the next rising edge
    task automatic step(input bit h_we, input logic [15:0] h, input bit l_we,
                        input logic [15:0] l, input bit c_we, input bit c_val,
                        input bit rdy, input bit busy);
        bit pop;
        @(negedge clk);
        hi_we = h_we; hi_data = h; lo_we = l_we; lo_data = l;
        clr_we = c_we; clr_val = c_val; cmd_ready = rdy; eng_busy = busy;
        pop = (m_q.size() != 0) && rdy;
        if (c_we && c_val) begin
            m_q.delete();
            m_ovf = 1'b0;
        end else begin
            bit was_full = (m_q.size() == DEPTH);
            if (pop) void'(m_q.pop_front());
            if (l_we) begin
                if (was_full) m_ovf = 1'b1;
                else m_q.push_back(exp_word(m_hi, l));
            end
        end
        if (h_we) m_hi = h;
        m_busy = busy;
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic nop();
        step(0, 16'h0, 0, 16'h0, 0, 0, 0, 0);
    endtask

    initial begin
        int unsigned seed;
        logic [31:0] head_before;
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        expect_eq("R1 pend_cnt", pend_cnt, 0);
        expect_eq("R1 free_cnt", free_cnt, DEPTH);
        expect_eq("R1 cmd_valid", cmd_valid, 0);
        expect_eq("R1 ovf", ovf, 0);

        // R2 high half alone queues nothing
        step(1, 16'h1234, 0, 16'h0, 0, 0, 0, 0);
        expect_eq("R2 high only pend", pend_cnt, 0);
        step(0, 16'h0, 1, 16'h5678, 0, 0, 0, 0);
        expect_eq("R2 joined word", cmd_data, 32'h12345678);
        // R3 reuse latched high half
        step(0, 16'h0, 1, 16'h9abc, 0, 0, 0, 0);
        // R3 same-cycle high and low
        step(1, 16'haaaa, 1, 16'h1111, 0, 0, 0, 0);
        step(0, 16'h0, 1, 16'h2222, 0, 0, 0, 0);
        step(0, 16'h0, 0, 16'h0, 0, 0, 1, 0);
        expect_eq("R3 reused high", cmd_data, 32'h12349abc);
        step(0, 16'h0, 0, 16'h0, 0, 0, 1, 0);
        expect_eq("R3 same-cycle uses old high", cmd_data, 32'h12341111);
        step(0, 16'h0, 0, 16'h0, 0, 0, 1, 0);
        expect_eq("R3 new high applies later", cmd_data, 32'haaaa2222);
        step(0, 16'h0, 0, 16'h0, 0, 0, 1, 0);
        // R9 ready with an empty queue
        step(0, 16'h0, 0, 16'h0, 0, 0, 1, 0);
        expect_eq("R9 empty ready pend", pend_cnt, 0);
        expect_eq("R9 empty ready valid", cmd_valid, 0);

        // fill to capacity
        step(1, 16'hc0de, 0, 16'h0, 0, 0, 0, 0);
        for (int i = 0; i < DEPTH; i++) step(0, 16'h0, 1, 16'(i), 0, 0, 0, 0);
        expect_eq("R5 full pend", pend_cnt, DEPTH);
        expect_eq("R5 full free", free_cnt, 0);
        head_before = cmd_data;
        step(0, 16'h0, 1, 16'hdead, 0, 0, 0, 0);
        expect_eq("R6 overflow flag", ovf, 1);
        expect_eq("R6 pend kept", pend_cnt, DEPTH);
        expect_eq("R6 head kept", cmd_data, head_before);
        // R6 push while full with a pop in the same cycle is still dropped
        step(0, 16'h0, 1, 16'hbeef, 0, 0, 1, 0);
        expect_eq("R6 full push with pop", pend_cnt, DEPTH - 1);
        // R10 push and pop together on a non-full queue
        step(0, 16'h0, 1, 16'h7777, 0, 0, 1, 0);
        expect_eq("R10 push pop pend", pend_cnt, DEPTH - 1);
        // R7 clear with value 0 is ignored
        step(0, 16'h0, 0, 16'h0, 1, 0, 0, 0);
        expect_eq("R7 clr zero pend", pend_cnt, DEPTH - 1);
        expect_eq("R7 clr zero ovf", ovf, 1);
        // R7 clear flushes and beats a same-cycle push
        step(0, 16'h0, 1, 16'h4444, 1, 1, 1, 0);
        expect_eq("R7 clear pend", pend_cnt, 0);
        expect_eq("R7 clear ovf", ovf, 0);
        // R8 busy engine keeps idle low
        step(0, 16'h0, 0, 16'h0, 0, 0, 0, 1);
        expect_eq("R8 busy idle", idle, 0);
        step(0, 16'h0, 0, 16'h0, 0, 0, 0, 0);
        expect_eq("R8 idle", idle, 1);

        // constrained random traffic, checked every cycle against the model
        for (int i = 0; i < 6000; i++) begin
            bit rh = ($urandom % 100) < 30;
            bit rl = ($urandom % 100) < 45;
            bit rc = ($urandom % 400) == 0;
            bit rv = ($urandom % 2) == 0;
            bit rr = ($urandom % 100) < ((i / 1000) % 2 == 0 ? 35 : 60);
            bit rb = ($urandom % 4) == 0;
            step(rh, 16'($urandom), rl, 16'($urandom), rc, rv, rr, rb);
        end
        // drain
        for (int i = 0; i < DEPTH + 4; i++) step(0, 16'h0, 0, 16'h0, 0, 0, 1, 0);
        expect_eq("R4 drained", cmd_valid, 0);
        nop();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule